// File: doc/BRIEF.md
# Slot Hotplug Event Register Bank

This block keeps the small set of I/O-mapped registers through which system firmware learns that a slot on the expansion bus has gained or lost a device. A hotplug event arrives as a one-cycle strobe carrying a slot number and an insert/remove flag. The block records the slot in one of two 32-bit bitmaps, an "arrived" map and a "departed" map. Both maps are cleared first, so only the newest event is visible. It also sets the hotplug bit in the general-purpose event status and enable registers and raises the system control interrupt for one clock.

Firmware reaches the registers through a simple 32-bit read/write port with address decoding. The two bitmaps are 32-bit words at 0xAE00 and 0xAE04. The eject register is a 32-bit word at 0xAE08. The general-purpose event status and enable registers sit in a byte-wide window at 0xAFE0. Writing a nonzero value to the eject register produces a one-cycle eject request. The request carries the index of the lowest set bit of the written value, and the logic that removes the device uses that index.

Top module: `slot_event_regs`

## Requirements
- R1: After reset, both slot bitmaps, the event status and enable registers, the interrupt line and the eject request are all zero.
- R2: An accepted insert event (ev_insert_i = 1) leaves the arrived map equal to exactly bit [slot] and the departed map equal to zero, whatever they held before.
- R3: An accepted remove event (ev_insert_i = 0) leaves the departed map equal to exactly bit [slot] and the arrived map equal to zero.
- R4: Every accepted event sets bit 1 of both the event status and the event enable register, and keeps their other bits.
- R5: The interrupt line is high for exactly the one cycle after each accepted event and low otherwise.
- R6: An event whose slot number is 32 or higher is ignored: the bitmaps and event registers stay unchanged and no interrupt pulse is produced.
- R7: A 32-bit write at 0xAE00 loads the arrived map and one at 0xAE04 loads the departed map. Reads at those addresses return the maps.
- R8: In the byte window at 0xAFE0, offsets 0 and 1 are the low and high bytes of the event status register, and offsets 2 and 3 are the low and high bytes of the enable register. Each byte travels on data bits [7:0]. A 1 written to a status bit clears it, a 0 leaves it unchanged, and the enable bytes are plain read/write.
- R9: Reads of the eject register at 0xAE08, and reads at any address outside the decoded locations, return zero.
- R10: A nonzero write to 0xAE08 gives, in the next cycle only, ej_req_o = 1, with ej_slot_o equal to the index of the lowest set bit of the written value.
- R11: A write of zero to 0xAE08 produces no eject request.
- R12: When an event and a firmware write to a bitmap or an event register land in the same cycle, the event's effect on the maps and on bit 1 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid_i | input | 1 | Hotplug event strobe |
| ev_slot_i | input | 6 | Slot number of the event (values of 32 and above are ignored) |
| ev_insert_i | input | 1 | 1 = device inserted, 0 = device removed |
| io_addr_i | input | 16 | I/O address |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe (read data is combinational) |
| io_wdata_i | input | 32 | Write data |
| io_rdata_o | output | 32 | Read data, zero when no read is requested |
| sci_o | output | 1 | System control interrupt pulse |
| ej_req_o | output | 1 | One-cycle eject request |
| ej_slot_o | output | 5 | Slot index for the eject request |

## Verification
The hardest case to reach is an event that collides with a firmware write to the very register it updates. Random traffic seldom lines the two up in one cycle. The bench drives the event strobe and a write of all ones to the arrived map on the same clock edge. It also drives an event together with a write-one-to-clear of the status byte that holds the hotplug bit, and then reads back to confirm that the event won. The eject decoder is swept over every slot with the bits above the lowest set bit filled in, so a decoder that picks the highest bit or any other set bit is exposed.

// File: rtl/hpreg_pkg.sv
package hpreg_pkg;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_UP,
      RG_DOWN,
      RG_EJECT,
      RG_GPE
   } region_e;

   typedef struct packed {
      region_e    rg;
      logic [1:0] ofs;
   } io_dec_t;

endpackage

// File: rtl/hpreg_io_decode.sv
module hpreg_io_decode #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned MAP_BASE = 32'hAE00,
   parameter int unsigned EJ_ADDR  = 32'hAE08,
   parameter int unsigned GPE_BASE = 32'hAFE0,
   parameter int unsigned GPE_SPAN = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output hpreg_pkg::io_dec_t dec
);
   import hpreg_pkg::*;

   localparam logic [ADDR_W-1:0] UP_A  = ADDR_W'(MAP_BASE);
   localparam logic [ADDR_W-1:0] DN_A  = ADDR_W'(MAP_BASE + 4);
   localparam logic [ADDR_W-1:0] EJ_A  = ADDR_W'(EJ_ADDR);
   localparam logic [ADDR_W-1:0] G_A   = ADDR_W'(GPE_BASE);
   localparam logic [ADDR_W-1:0] G_LIM = ADDR_W'(GPE_SPAN);

   generate
      if (GPE_SPAN < 2 || GPE_SPAN > 4) begin : g_bad_span
         $error("hpreg_io_decode: GPE_SPAN must lie in 2..4");
      end
      if (ADDR_W < 4) begin : g_bad_aw
         $error("hpreg_io_decode: ADDR_W too small");
      end
   endgenerate

   logic [ADDR_W-1:0] gofs;
   assign gofs = addr - G_A;

   always_comb begin
      dec.rg  = RG_NONE;
      dec.ofs = gofs[1:0];
      if (addr == UP_A) begin
         dec.rg = RG_UP;
      end else if (addr == DN_A) begin
         dec.rg = RG_DOWN;
      end else if (addr == EJ_A) begin
         dec.rg = RG_EJECT;
      end else if (gofs < G_LIM) begin
         dec.rg = RG_GPE;
      end
   end

endmodule

// File: rtl/hpreg_first_set.sv
module hpreg_first_set #(
   parameter int unsigned W    = 32,
   parameter int unsigned IMPL = 1,
   localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic [IDX_W-1:0] idx
);

   generate
      if (IMPL == 0) begin : g_scan
         always_comb begin
            idx = '0;
            for (int i = W - 1; i >= 0; i--) begin
               if (vec[i]) idx = IDX_W'(i);
            end
         end
      end else if (IMPL == 1) begin : g_isolate
         logic [W-1:0] iso;
         assign iso = vec & (~vec + W'(1));
         always_comb begin
            idx = '0;
            for (int i = 0; i < W; i++) begin
               if (iso[i]) idx = idx | IDX_W'(i);
            end
         end
      end else begin : g_bad_impl
         $error("hpreg_first_set: IMPL must be 0 or 1");
      end
   endgenerate

endmodule

// File: rtl/hpreg_slot_maps.sv
module hpreg_slot_maps #(
   parameter int unsigned SLOT_W = 32,
   localparam int unsigned IDX_W = $clog2(SLOT_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_fire,
   input  logic [IDX_W-1:0]  ev_idx,
   input  logic              ev_insert,
   input  logic              wr_up,
   input  logic              wr_down,
   input  logic [SLOT_W-1:0] wdata,
   output logic [SLOT_W-1:0] up_q,
   output logic [SLOT_W-1:0] down_q
);

   logic [SLOT_W-1:0] onehot;
   assign onehot = SLOT_W'(1) << ev_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up_q   <= '0;
         down_q <= '0;
      end else if (ev_fire) begin
         up_q   <= ev_insert ? onehot : '0;
         down_q <= ev_insert ? '0 : onehot;
      end else begin
         if (wr_up)   up_q   <= wdata;
         if (wr_down) down_q <= wdata;
      end
   end

endmodule

// File: rtl/hpreg_gpe_bank.sv
module hpreg_gpe_bank #(
   parameter int unsigned GPE_W  = 16,
   parameter int unsigned HP_BIT = 1,
   localparam int unsigned NB     = GPE_W / 8,
   localparam int unsigned BSEL_W = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_fire,
   input  logic              wr_sts,
   input  logic              wr_en,
   input  logic [BSEL_W-1:0] bsel,
   input  logic [7:0]        wbyte,
   output logic [GPE_W-1:0]  sts_q,
   output logic [GPE_W-1:0]  en_q
);

   generate
      if (GPE_W % 8 != 0 || GPE_W < 8 || GPE_W > 16) begin : g_bad_w
         $error("hpreg_gpe_bank: GPE_W must be 8 or 16");
      end
      if (HP_BIT >= GPE_W) begin : g_bad_bit
         $error("hpreg_gpe_bank: HP_BIT outside register");
      end

      for (genvar b = 0; b < NB; b++) begin : g_byte
         localparam logic [7:0] HP_MASK =
            ((HP_BIT / 8) == b) ? 8'(1 << (HP_BIT % 8)) : 8'h00;
         logic       hit;
         logic [7:0] s_q, e_q, s_nx, e_nx;

         assign hit = (bsel == BSEL_W'(b));

         always_comb begin
            s_nx = (wr_sts && hit) ? (s_q & ~wbyte) : s_q;
            e_nx = (wr_en  && hit) ? wbyte : e_q;
            if (ev_fire) begin
               s_nx = s_nx | HP_MASK;
               e_nx = e_nx | HP_MASK;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               s_q <= '0;
               e_q <= '0;
            end else begin
               s_q <= s_nx;
               e_q <= e_nx;
            end
         end

         assign sts_q[b*8 +: 8] = s_q;
         assign en_q[b*8 +: 8]  = e_q;
      end
   endgenerate

endmodule

// File: rtl/slot_event_regs.sv
module slot_event_regs #(
   parameter int unsigned SLOT_W     = 32,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MAP_BASE   = 32'hAE00,
   parameter int unsigned EJ_ADDR    = 32'hAE08,
   parameter int unsigned GPE_BASE   = 32'hAFE0,
   parameter int unsigned GPE_W      = 16,
   parameter int unsigned HP_GPE_BIT = 1,
   parameter int unsigned FFS_IMPL   = 1,
   localparam int unsigned IDX_W = $clog2(SLOT_W),
   localparam int unsigned EVS_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid_i,
   input  logic [EVS_W-1:0]  ev_slot_i,
   input  logic              ev_insert_i,
   input  logic [ADDR_W-1:0] io_addr_i,
   input  logic              io_wr_i,
   input  logic              io_rd_i,
   input  logic [DATA_W-1:0] io_wdata_i,
   output logic [DATA_W-1:0] io_rdata_o,
   output logic              sci_o,
   output logic              ej_req_o,
   output logic [IDX_W-1:0]  ej_slot_o
);
   import hpreg_pkg::*;

   localparam int unsigned GPE_NB   = GPE_W / 8;
   localparam int unsigned GPE_SPAN = 2 * GPE_NB;
   localparam int unsigned BSEL_W   = (GPE_NB > 1) ? $clog2(GPE_NB) : 1;

   generate
      if (SLOT_W < 2 || SLOT_W > DATA_W || (SLOT_W & (SLOT_W - 1)) != 0) begin : g_bad_slots
         $error("slot_event_regs: SLOT_W must be a power of two no wider than DATA_W");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("slot_event_regs: DATA_W must be at least 8");
      end
   endgenerate

   io_dec_t dec;

   hpreg_io_decode #(
      .ADDR_W  (ADDR_W),
      .MAP_BASE(MAP_BASE),
      .EJ_ADDR (EJ_ADDR),
      .GPE_BASE(GPE_BASE),
      .GPE_SPAN(GPE_SPAN)
   ) u_dec (
      .addr(io_addr_i),
      .dec (dec)
   );

   logic             ev_fire;
   logic [IDX_W-1:0] ev_idx;
   assign ev_fire = ev_valid_i && (ev_slot_i < EVS_W'(SLOT_W));
   assign ev_idx  = ev_slot_i[IDX_W-1:0];

   logic [SLOT_W-1:0] up_map, down_map;

   hpreg_slot_maps #(.SLOT_W(SLOT_W)) u_maps (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_fire  (ev_fire),
      .ev_idx   (ev_idx),
      .ev_insert(ev_insert_i),
      .wr_up    (io_wr_i && dec.rg == RG_UP),
      .wr_down  (io_wr_i && dec.rg == RG_DOWN),
      .wdata    (io_wdata_i[SLOT_W-1:0]),
      .up_q     (up_map),
      .down_q   (down_map)
   );

   logic              g_hit, g_in_en;
   logic [BSEL_W-1:0] g_bsel;
   logic [GPE_W-1:0]  gpe_sts, gpe_en;

   assign g_hit   = io_wr_i && dec.rg == RG_GPE;
   assign g_in_en = (32'(dec.ofs) >= GPE_NB);
   assign g_bsel  = g_in_en ? BSEL_W'(32'(dec.ofs) - GPE_NB) : BSEL_W'(dec.ofs);

   hpreg_gpe_bank #(.GPE_W(GPE_W), .HP_BIT(HP_GPE_BIT)) u_gpe (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_fire(ev_fire),
      .wr_sts (g_hit && !g_in_en),
      .wr_en  (g_hit && g_in_en),
      .bsel   (g_bsel),
      .wbyte  (io_wdata_i[7:0]),
      .sts_q  (gpe_sts),
      .en_q   (gpe_en)
   );

   logic [IDX_W-1:0] ffs_idx;
   logic             ej_fire;

   hpreg_first_set #(.W(SLOT_W), .IMPL(FFS_IMPL)) u_ffs (
      .vec(io_wdata_i[SLOT_W-1:0]),
      .idx(ffs_idx)
   );

   assign ej_fire = io_wr_i && dec.rg == RG_EJECT && (|io_wdata_i[SLOT_W-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sci_o     <= 1'b0;
         ej_req_o  <= 1'b0;
         ej_slot_o <= '0;
      end else begin
         sci_o    <= ev_fire;
         ej_req_o <= ej_fire;
         if (ej_fire) ej_slot_o <= ffs_idx;
      end
   end

   logic [2*GPE_W-1:0] gpe_cat;
   assign gpe_cat = {gpe_en, gpe_sts};

   always_comb begin
      io_rdata_o = '0;
      if (io_rd_i) begin
         unique case (dec.rg)
            RG_UP:   io_rdata_o = DATA_W'(up_map);
            RG_DOWN: io_rdata_o = DATA_W'(down_map);
            RG_GPE:  io_rdata_o = DATA_W'(gpe_cat[32'(dec.ofs)*8 +: 8]);
            default: io_rdata_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/slot_event_regs_chk.sv
module slot_event_regs_chk #(
   parameter int unsigned SLOT_W     = 32,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned EJ_ADDR    = 32'hAE08,
   parameter int unsigned GPE_W      = 16,
   parameter int unsigned HP_GPE_BIT = 1,
   localparam int unsigned IDX_W = $clog2(SLOT_W),
   localparam int unsigned EVS_W = IDX_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_valid_i,
   input logic [EVS_W-1:0]  ev_slot_i,
   input logic              ev_insert_i,
   input logic [ADDR_W-1:0] io_addr_i,
   input logic              io_wr_i,
   input logic [DATA_W-1:0] io_wdata_i,
   input logic              sci_o,
   input logic              ej_req_o,
   input logic [IDX_W-1:0]  ej_slot_o,
   input logic [SLOT_W-1:0] up_map,
   input logic [SLOT_W-1:0] down_map,
   input logic [GPE_W-1:0]  gpe_sts,
   input logic [GPE_W-1:0]  gpe_en
);

   logic ok_ev;
   logic ej_wr;
   assign ok_ev = ev_valid_i && (32'(ev_slot_i) < SLOT_W);
   assign ej_wr = io_wr_i && (32'(io_addr_i) == EJ_ADDR) && (|io_wdata_i[SLOT_W-1:0]);

   // R2
   insert_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok_ev && ev_insert_i |=> up_map == (SLOT_W'(1) << $past(ev_slot_i[IDX_W-1:0])) && down_map == '0);

   // R3
   remove_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok_ev && !ev_insert_i |=> down_map == (SLOT_W'(1) << $past(ev_slot_i[IDX_W-1:0])) && up_map == '0);

   // R4
   gpe_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok_ev |=> gpe_sts[HP_GPE_BIT] && gpe_en[HP_GPE_BIT]);

   // R5
   sci_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sci_o |-> $past(ok_ev));

   // R5
   sci_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok_ev |=> sci_o);

   // R6
   far_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ok_ev && !io_wr_i |=> $stable(up_map) && $stable(down_map) && !sci_o);

   // R10
   ej_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ej_req_o |-> $past(ej_wr));

   // R10
   ej_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ej_req_o |-> ((($past(io_wdata_i) >> ej_slot_o) & 1) == 1) &&
                   (($past(io_wdata_i) & ((DATA_W'(1) << ej_slot_o) - 1)) == '0));

endmodule

bind slot_event_regs slot_event_regs_chk #(
   .SLOT_W    (SLOT_W),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .EJ_ADDR   (EJ_ADDR),
   .GPE_W     (GPE_W),
   .HP_GPE_BIT(HP_GPE_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev_valid_i (ev_valid_i),
   .ev_slot_i  (ev_slot_i),
   .ev_insert_i(ev_insert_i),
   .io_addr_i  (io_addr_i),
   .io_wr_i    (io_wr_i),
   .io_wdata_i (io_wdata_i),
   .sci_o      (sci_o),
   .ej_req_o   (ej_req_o),
   .ej_slot_o  (ej_slot_o),
   .up_map     (up_map),
   .down_map   (down_map),
   .gpe_sts    (gpe_sts),
   .gpe_en     (gpe_en)
);

// File: tb/tb_slot_event_regs.sv
module tb_slot_event_regs;

   localparam logic [15:0] A_UP   = 16'hAE00;
   localparam logic [15:0] A_DOWN = 16'hAE04;
   localparam logic [15:0] A_EJ   = 16'hAE08;
   localparam logic [15:0] A_GPE  = 16'hAFE0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid_i = 1'b0;
   logic [5:0]  ev_slot_i = '0;
   logic        ev_insert_i = 1'b0;
   logic [15:0] io_addr_i = '0;
   logic        io_wr_i = 1'b0;
   logic        io_rd_i = 1'b0;
   logic [31:0] io_wdata_i = '0;
   logic [31:0] io_rdata_o;
   logic        sci_o;
   logic        ej_req_o;
   logic [4:0]  ej_slot_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   slot_event_regs dut (
      .clk(clk), .rst_n(rst_n),
      .ev_valid_i(ev_valid_i), .ev_slot_i(ev_slot_i), .ev_insert_i(ev_insert_i),
      .io_addr_i(io_addr_i), .io_wr_i(io_wr_i), .io_rd_i(io_rd_i),
      .io_wdata_i(io_wdata_i), .io_rdata_o(io_rdata_o),
      .sci_o(sci_o), .ej_req_o(ej_req_o), .ej_slot_o(ej_slot_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      io_addr_i = a; io_wdata_i = d; io_wr_i = 1'b1;
      @(negedge clk);
      io_wr_i = 1'b0;
   endtask

   task automatic io_read(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      io_addr_i = a; io_rd_i = 1'b1;
      #1 d = io_rdata_o;
      io_rd_i = 1'b0;
   endtask

   task automatic hp_event(input int s, input bit ins);
      @(negedge clk);
      ev_slot_i = 6'(s); ev_insert_i = ins; ev_valid_i = 1'b1;
      @(negedge clk);
      ev_valid_i = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end

   initial begin
      logic [31:0] rd, up_save, dn_save;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 sci", 32'(sci_o), 0);
      check("R1 ej_req", 32'(ej_req_o), 0);
      io_read(A_UP, rd);   check("R1 up", rd, 0);
      io_read(A_DOWN, rd); check("R1 down", rd, 0);
      for (int o = 0; o < 4; o++) begin
         io_read(A_GPE + 16'(o), rd); check("R1 gpe", rd, 0);
      end

      // R2 R3 R5: every slot, both kinds
      for (int s = 0; s < 32; s++) begin
         for (int k = 0; k < 2; k++) begin
            hp_event(s, k[0]);
            check("R5 sci pulse", 32'(sci_o), 1);
            @(negedge clk);
            check("R5 sci low", 32'(sci_o), 0);
            io_read(A_UP, rd);
            check(k[0] ? "R2 up" : "R3 up", rd, k[0] ? (32'd1 << s) : 32'd0);
            io_read(A_DOWN, rd);
            check(k[0] ? "R2 down" : "R3 down", rd, k[0] ? 32'd0 : (32'd1 << s));
         end
      end

      // R7: direct bitmap access
      io_write(A_UP, 32'h1234_5678);
      io_write(A_DOWN, 32'h9ABC_DEF0);
      io_read(A_UP, rd);   check("R7 up", rd, 32'h1234_5678);
      io_read(A_DOWN, rd); check("R7 down", rd, 32'h9ABC_DEF0);

      // R8: status bit 1 is set now, clear it by writing one
      io_read(A_GPE, rd); check("R4 sts bit1", rd, 32'h02);
      io_write(A_GPE, 32'h0000_0002);
      io_read(A_GPE, rd); check("R8 sts w1c", rd, 0);
      io_write(A_GPE + 16'd1, 32'hFF);
      io_read(A_GPE + 16'd1, rd); check("R8 sts no set", rd, 0);
      io_write(A_GPE + 16'd2, 32'hA5);
      io_write(A_GPE + 16'd3, 32'h3C);
      io_read(A_GPE + 16'd2, rd); check("R8 en lo", rd, 32'hA5);
      io_read(A_GPE + 16'd3, rd); check("R8 en hi", rd, 32'h3C);

      // R6: out-of-range slots change nothing
      io_read(A_UP, up_save);
      io_read(A_DOWN, dn_save);
      for (int s = 32; s < 64; s++) begin
         hp_event(s, s[0]);
         check("R6 no sci", 32'(sci_o), 0);
      end
      io_read(A_UP, rd);   check("R6 up", rd, up_save);
      io_read(A_DOWN, rd); check("R6 down", rd, dn_save);
      io_read(A_GPE, rd);  check("R6 sts", rd, 0);

      // R4: event ORs bit 1, keeps other enable bits
      hp_event(9, 1'b1);
      io_read(A_GPE + 16'd2, rd); check("R4 en lo", rd, 32'hA7);
      io_read(A_GPE + 16'd3, rd); check("R4 en hi", rd, 32'h3C);
      io_read(A_GPE, rd);         check("R4 sts", rd, 32'h02);

      // R9: zero reads
      io_read(A_EJ, rd);            check("R9 eject read", rd, 0);
      io_read(16'hAE0C, rd);        check("R9 undecoded", rd, 0);
      io_read(A_GPE + 16'd4, rd);   check("R9 undecoded", rd, 0);
      io_read(16'h0000, rd);        check("R9 undecoded", rd, 0);

      // R10: lowest set bit, higher bits filled
      for (int k = 0; k < 32; k++) begin
         logic [63:0] hi_mask;
         hi_mask = ~((64'd1 << (k + 1)) - 64'd1);
         io_write(A_EJ, (32'd1 << k) | (32'hB6D5_AF3F & hi_mask[31:0]));
         check("R10 req", 32'(ej_req_o), 1);
         check("R10 slot", 32'(ej_slot_o), 32'(k));
         @(negedge clk);
         check("R10 one cycle", 32'(ej_req_o), 0);
      end

      // R11: zero write
      io_write(A_EJ, 32'h0);
      check("R11 no req", 32'(ej_req_o), 0);
      @(negedge clk);
      check("R11 no req later", 32'(ej_req_o), 0);

      // R12: event collides with writes
      @(negedge clk);
      io_addr_i = A_UP; io_wdata_i = 32'hFFFF_FFFF; io_wr_i = 1'b1;
      ev_slot_i = 6'd3; ev_insert_i = 1'b0; ev_valid_i = 1'b1;
      @(negedge clk);
      io_wr_i = 1'b0; ev_valid_i = 1'b0;
      io_read(A_UP, rd);   check("R12 up", rd, 0);
      io_read(A_DOWN, rd); check("R12 down", rd, 32'h8);
      @(negedge clk);
      io_addr_i = A_GPE; io_wdata_i = 32'hFF; io_wr_i = 1'b1;
      ev_slot_i = 6'd7; ev_insert_i = 1'b1; ev_valid_i = 1'b1;
      @(negedge clk);
      io_wr_i = 1'b0; ev_valid_i = 1'b0;
      io_read(A_GPE, rd);  check("R12 sts", rd, 32'h02);

      done = 1'b1;
      finish_run();
   end

endmodule